// File: doc/BRIEF.md
# Buffered Fast-Program Flash Block Writer

This block is the host-side sequencer that loads one flash block with factory data using the device's buffered fast-program mode. A client hands it the first-word address of the target block and a word count through a start pulse, then supplies the data words over a valid/ready stream. The writer opens the mode with a setup write and a confirm write. It lets the device settle for a fixed delay, then reads status to catch setup failures and to learn when the device's internal buffer will take data.

Data goes to the device in bursts of exactly 32 writes, all at the same aligned first-word address. A short final burst is topped up with all-ones words. Before every burst, and before leaving the mode, the writer polls status with plain reads. It never sends a status command while streaming, and it never reads the data back, because it relies on the device's own verify. To leave the mode it writes once to the address one block above the base, then polls until the device reports ready. The outcome is a `done` level together with a 3-bit result code.

The flash bus has one-cycle transfers: a write puts address and data out for one cycle with `flWe` high, and a read raises `flRe` for one cycle and samples `flRdData` at the same clock edge.

Top module: `flash_burst_prog`

## Requirements
- R1: A start whose base address has any of bits [4:0] set ends the job without a single bus read or write. The next cycle shows done=1 with result code 1 (alignment), and busy never rises.
- R2: An accepted job begins with two writes at the base address: first the setup command 0x0080, then the confirm command 0x00D0.
- R3: After the confirm write, the first status read comes no sooner than STARTUP_DLY cycles later.
- R4: If a status read during the setup or buffer poll has bit 4 set, the job stops with no further writes. The result code is 2 when bit 1 is also set (locked block). It is 3 when bit 1 is clear and bit 3 is set (supply level). Otherwise it is 4.
- R5: Every burst, including the first, starts only after a status read that returned bit 7 = 0 and bit 0 = 1. The writer waits for such a read again before the exit write.
- R6: Every burst is exactly 32 data writes, and every data write uses the base address. Each write the block makes has address bits [4:0] equal to zero.
- R7: The data writes carry the stream words in arrival order. The positions after the last stream word, up to the end of its burst, carry 0xFFFF. While streaming, status is obtained by reads only.
- R8: inReady is high only while real stream words are outstanding, and exactly wordCount words are taken. A count of zero takes none and writes no burst.
- R9: After the last burst, the writer makes one write of 0xFFFF at base + BLOCK_WORDS (modulo the address width). It then polls until bit 7 is set, and finishes with result code 0.
- R10: If POLL_LIMIT consecutive status reads in one poll never show the awaited condition, the job ends with result code 5 after exactly POLL_LIMIT reads.
- R11: busy is high from the cycle after an accepted start until the job ends. done is cleared by the next start, and it is never high while busy is high.
- R12: A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job request, taken when idle |
| baseAddr | input | ADDR_W | First-word address of the target block |
| wordCount | input | CNT_W | Number of stream words to program |
| inData | input | DATA_W | Stream data word |
| inValid | input | 1 | Stream word available |
| inReady | output | 1 | Writer takes the stream word this cycle |
| flAddr | output | ADDR_W | Flash bus address |
| flWrData | output | DATA_W | Flash bus write data |
| flRdData | input | DATA_W | Flash bus read data (status in bits 7:0) |
| flWe | output | 1 | Flash write strobe, one cycle per write |
| flRe | output | 1 | Flash read strobe, one cycle per read |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished, held until next start |
| errCode | output | 3 | Result: 0 ok, 1 alignment, 2 locked, 3 supply, 4 program, 5 timeout |

## Verification
The assertions run on every cycle. They check that each write address is aligned, that reads and writes never collide, that the poll counter stays inside its limit, that done and busy are exclusive, that an unaligned start is rejected at once, and that streaming only ever follows a read showing the buffer free. The bench scenarios are needed for the rest: the exact command order, the settle gap, word order and padding across partial and multiple bursts, how many stream words are consumed, the placement of the exit write, the decoding of each status error combination, and the exact read count at which a poll gives up.

// File: rtl/flash_burst_pkg.sv
package flash_burst_pkg;

  // bus operation selected by the control for the current cycle
  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_CONFIRM,
    BUS_DATA,
    BUS_PAD,
    BUS_EXIT,
    BUS_POLL
  } busSel_e;

  // strobes from control to datapath
  typedef struct packed {
    busSel_e busSel;
    logic    loadCfg;
    logic    clrBurst;
    logic    loadDelay;
    logic    clrPoll;
    logic    incPoll;
  } dpStrobe_t;

  // result codes
  localparam logic [2:0] RES_OK      = 3'd0;
  localparam logic [2:0] RES_ALIGN   = 3'd1;
  localparam logic [2:0] RES_LOCKED  = 3'd2;
  localparam logic [2:0] RES_SUPPLY  = 3'd3;
  localparam logic [2:0] RES_PROG    = 3'd4;
  localparam logic [2:0] RES_TIMEOUT = 3'd5;

  // status bit positions the device reports
  localparam int ST_READY = 7;
  localparam int ST_FAIL  = 4;
  localparam int ST_VOLT  = 3;
  localparam int ST_LOCK  = 1;
  localparam int ST_BUF   = 0;

endpackage

// File: rtl/flash_burst_dp.sv
module flash_burst_dp
  import flash_burst_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int BURST_LEN   = 32,
  parameter int STARTUP_DLY = 6,
  parameter int POLL_LIMIT  = 40,
  parameter int BLOCK_WORDS = 1024,
  parameter int CMD_SETUP   = 'h80,
  parameter int CMD_CONFIRM = 'hD0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWrData,
  output logic              flWe,
  output logic              flRe,
  output logic              alignBad,
  output logic              remainZero,
  output logic              burstLast,
  output logic              wordMove,
  output logic              delayDone,
  output logic              pollLast
);

  localparam int IDX_W  = $clog2(BURST_LEN);
  localparam int DLY_W  = $clog2(STARTUP_DLY + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  logic [ADDR_W-1:0] baseReg;
  logic [CNT_W-1:0]  remain;
  logic [IDX_W-1:0]  burstIdx;
  logic [DLY_W-1:0]  delayCnt;
  logic [POLL_W-1:0] pollCnt;

  assign alignBad   = |baseIn[IDX_W-1:0];
  assign remainZero = (remain == '0);
  assign burstLast  = (burstIdx == IDX_W'(BURST_LEN - 1));
  assign delayDone  = (delayCnt == '0);
  assign pollLast   = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign wordMove   = (strb.busSel == BUS_DATA && inValid) || (strb.busSel == BUS_PAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      remain   <= '0;
      burstIdx <= '0;
      delayCnt <= '0;
      pollCnt  <= '0;
    end else begin
      if (strb.loadCfg) begin
        baseReg <= baseIn;
        remain  <= countIn;
      end else if (strb.busSel == BUS_DATA && inValid) begin
        remain <= remain - 1'b1;
      end
      if (strb.clrBurst)   burstIdx <= '0;
      else if (wordMove)   burstIdx <= burstIdx + 1'b1;
      if (strb.loadDelay)  delayCnt <= DLY_W'(STARTUP_DLY);
      else if (!delayDone) delayCnt <= delayCnt - 1'b1;
      if (strb.clrPoll)      pollCnt <= '0;
      else if (strb.incPoll) pollCnt <= pollCnt + 1'b1;
    end
  end

  always_comb begin
    flAddr   = baseReg;
    flWrData = '1;
    flWe     = 1'b0;
    flRe     = 1'b0;
    inReady  = 1'b0;
    unique case (strb.busSel)
      BUS_SETUP: begin
        flWe     = 1'b1;
        flWrData = DATA_W'(CMD_SETUP);
      end
      BUS_CONFIRM: begin
        flWe     = 1'b1;
        flWrData = DATA_W'(CMD_CONFIRM);
      end
      BUS_DATA: begin
        inReady  = 1'b1;
        flWe     = inValid;
        flWrData = inData;
      end
      BUS_PAD:  flWe = 1'b1;
      BUS_EXIT: begin
        flWe   = 1'b1;
        flAddr = baseReg + ADDR_W'(BLOCK_WORDS);
      end
      BUS_POLL: flRe = 1'b1;
      default: ;
    endcase
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    flWe |-> (flAddr[IDX_W-1:0] == '0)); // R6
  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(flWe && flRe)); // R12
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < POLL_W'(POLL_LIMIT)); // R10

endmodule

// File: rtl/flash_burst_ctrl.sv
module flash_burst_ctrl
  import flash_burst_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      alignBad,
  input  logic      remainZero,
  input  logic      burstLast,
  input  logic      wordMove,
  input  logic      delayDone,
  input  logic      pollLast,
  input  logic [7:0] status,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      done,
  output logic [2:0] errCode
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_CONFIRM, S_WAIT, S_POLL, S_STREAM, S_EXIT, S_XPOLL
  } state_e;

  state_e     state, nextState;
  logic       finishNow;
  logic [2:0] finishCode;
  logic       doneReg;
  logic [2:0] errReg;

  function automatic logic [2:0] failCause(input logic [7:0] st);
    if (st[ST_LOCK])      return RES_LOCKED;
    else if (st[ST_VOLT]) return RES_SUPPLY;
    else                  return RES_PROG;
  endfunction

  always_comb begin
    strb       = '{busSel: BUS_IDLE, default: 1'b0};
    nextState  = state;
    finishNow  = 1'b0;
    finishCode = RES_OK;
    unique case (state)
      S_IDLE: if (start) begin
        if (alignBad) begin
          finishNow  = 1'b1;
          finishCode = RES_ALIGN;
        end else begin
          strb.loadCfg = 1'b1;
          nextState    = S_SETUP;
        end
      end
      S_SETUP: begin
        strb.busSel = BUS_SETUP;
        nextState   = S_CONFIRM;
      end
      S_CONFIRM: begin
        strb.busSel    = BUS_CONFIRM;
        strb.loadDelay = 1'b1;
        nextState      = S_WAIT;
      end
      S_WAIT: if (delayDone) begin
        strb.clrPoll = 1'b1;
        nextState    = S_POLL;
      end
      S_POLL: begin
        strb.busSel = BUS_POLL;
        if (status[ST_FAIL]) begin
          finishNow  = 1'b1;
          finishCode = failCause(status);
          nextState  = S_IDLE;
        end else if (!status[ST_READY] && status[ST_BUF]) begin
          strb.clrBurst = 1'b1;
          nextState     = remainZero ? S_EXIT : S_STREAM;
        end else if (pollLast) begin
          finishNow  = 1'b1;
          finishCode = RES_TIMEOUT;
          nextState  = S_IDLE;
        end else begin
          strb.incPoll = 1'b1;
        end
      end
      S_STREAM: begin
        strb.busSel = remainZero ? BUS_PAD : BUS_DATA;
        if (wordMove && burstLast) begin
          strb.clrPoll = 1'b1;
          nextState    = S_POLL;
        end
      end
      S_EXIT: begin
        strb.busSel  = BUS_EXIT;
        strb.clrPoll = 1'b1;
        nextState    = S_XPOLL;
      end
      S_XPOLL: begin
        strb.busSel = BUS_POLL;
        if (status[ST_READY]) begin
          finishNow  = 1'b1;
          finishCode = status[ST_FAIL] ? failCause(status) : RES_OK;
          nextState  = S_IDLE;
        end else if (pollLast) begin
          finishNow  = 1'b1;
          finishCode = RES_TIMEOUT;
          nextState  = S_IDLE;
        end else begin
          strb.incPoll = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      doneReg <= 1'b0;
      errReg  <= RES_OK;
    end else begin
      state <= nextState;
      if (finishNow) begin
        doneReg <= 1'b1;
        errReg  <= finishCode;
      end else if (state == S_IDLE && start) begin
        doneReg <= 1'b0;
        errReg  <= RES_OK;
      end
    end
  end

  assign busy    = (state != S_IDLE);
  assign done    = doneReg;
  assign errCode = errReg;

  AST_ALIGN_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && alignBad) |=> (done && errCode == RES_ALIGN && !busy)); // R1
  AST_STREAM_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STREAM && $past(state) != S_STREAM) |->
      ($past(state) == S_POLL && $past(status[ST_BUF]) && !$past(status[ST_READY]))); // R5

endmodule

// File: rtl/flash_burst_prog.sv
module flash_burst_prog
  import flash_burst_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int BURST_LEN   = 32,
  parameter int STARTUP_DLY = 6,
  parameter int POLL_LIMIT  = 40,
  parameter int BLOCK_WORDS = 1024,
  parameter int CMD_SETUP   = 'h80,
  parameter int CMD_CONFIRM = 'hD0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flWrData,
  input  logic [DATA_W-1:0] flRdData,
  output logic              flWe,
  output logic              flRe,
  output logic              busy,
  output logic              done,
  output logic [2:0]        errCode
);

  dpStrobe_t strb;
  logic alignBad, remainZero, burstLast, wordMove, delayDone, pollLast;

  flash_burst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .alignBad   (alignBad),
    .remainZero (remainZero),
    .burstLast  (burstLast),
    .wordMove   (wordMove),
    .delayDone  (delayDone),
    .pollLast   (pollLast),
    .status     (flRdData[7:0]),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .errCode    (errCode)
  );

  flash_burst_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CNT_W       (CNT_W),
    .BURST_LEN   (BURST_LEN),
    .STARTUP_DLY (STARTUP_DLY),
    .POLL_LIMIT  (POLL_LIMIT),
    .BLOCK_WORDS (BLOCK_WORDS),
    .CMD_SETUP   (CMD_SETUP),
    .CMD_CONFIRM (CMD_CONFIRM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .baseIn     (baseAddr),
    .countIn    (wordCount),
    .inData     (inData),
    .inValid    (inValid),
    .inReady    (inReady),
    .flAddr     (flAddr),
    .flWrData   (flWrData),
    .flWe       (flWe),
    .flRe       (flRe),
    .alignBad   (alignBad),
    .remainZero (remainZero),
    .burstLast  (burstLast),
    .wordMove   (wordMove),
    .delayDone  (delayDone),
    .pollLast   (pollLast)
  );

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)); // R11
  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy); // R8

endmodule

// File: tb/flash_burst_prog_test.sv
module flash_burst_prog_test;

  localparam int DLY   = 6;
  localparam int LIMIT = 40;
  localparam int LOGN  = 160;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] baseAddr = '0;
  logic [7:0]  wordCount = '0;
  logic [15:0] inData;
  logic        inValid;
  logic        inReady;
  logic [15:0] flAddr, flWrData, flRdData;
  logic        flWe, flRe, busy, done;
  logic [2:0]  errCode;

  flash_burst_prog uut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .wordCount(wordCount),
    .inData(inData), .inValid(inValid), .inReady(inReady), .flAddr(flAddr),
    .flWrData(flWrData), .flRdData(flRdData), .flWe(flWe), .flRe(flRe),
    .busy(busy), .done(done), .errCode(errCode)
  );

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // job configuration (set by tasks at negedge)
  logic       modelClr = 1'b0;
  logic       gaps = 1'b0;
  logic       errMode = 1'b0;
  logic [7:0] errBits = '0;
  logic       stuck = 1'b0;
  int         bufDelay = 0;
  int         exitDelay = 0;
  int         nWords = 0;

  // flash model state (owned by the posedge block)
  logic [15:0] wAddr [LOGN];
  logic [15:0] wData [LOGN];
  int wIdx, rCount, dataWrites, sent, notReady, exitLeft, viol;
  int confirmCyc, firstReadCyc;
  logic exitSeen, grant, rwClash;

  function automatic logic [7:0] srNow();
    if (errMode && !exitSeen) return 8'h90 | errBits;
    if (stuck) return 8'h00;
    if (exitSeen) return (exitLeft > 0) ? 8'h00 : 8'h80;
    return (notReady > 0) ? 8'h00 : 8'h01;
  endfunction

  assign flRdData = {8'h00, srNow()};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (modelClr) begin
      wIdx <= 0; rCount <= 0; dataWrites <= 0; sent <= 0; notReady <= 0;
      exitLeft <= 0; viol <= 0; confirmCyc <= -1; firstReadCyc <= -1;
      exitSeen <= 1'b0; grant <= 1'b0; rwClash <= 1'b0;
    end else begin
      if (inValid && inReady) sent <= sent + 1;
      if (flWe && flRe) rwClash <= 1'b1;
      if (flWe) begin
        if (wIdx < LOGN) begin
          wAddr[wIdx] <= flAddr;
          wData[wIdx] <= flWrData;
        end
        wIdx <= wIdx + 1;
        if (wIdx == 1) begin
          confirmCyc <= cyc;
          notReady   <= bufDelay;
        end else if (wIdx >= 2 && flAddr == baseAddr + 16'd1024) begin
          exitSeen <= 1'b1;
          exitLeft <= exitDelay;
        end else if (wIdx >= 2) begin
          dataWrites <= dataWrites + 1;
          if (dataWrites % 32 == 0) begin
            if (!grant) viol <= viol + 1;
            grant <= 1'b0;
          end
          if (dataWrites % 32 == 31) notReady <= bufDelay;
        end
      end
      if (flRe) begin
        rCount <= rCount + 1;
        if (firstReadCyc < 0) firstReadCyc <= cyc;
        if (srNow() == 8'h01) grant <= 1'b1;
        if (notReady > 0) notReady <= notReady - 1;
        if (exitSeen && exitLeft > 0) exitLeft <= exitLeft - 1;
      end
    end
  end

  always @(negedge clk) begin
    inData  <= 16'h5A00 + 16'(sent);
    inValid <= (sent < nWords) && !(gaps && (cyc % 3 == 0));
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string what, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
    end
  endtask

  task automatic launch(input logic [15:0] base, input int n);
    @(negedge clk);
    modelClr  = 1'b1;
    baseAddr  = base;
    wordCount = 8'(n);
    nWords    = n;
    @(negedge clk);
    modelClr = 1'b0;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 6000; i++) begin
      if (done) return;
      @(negedge clk);
    end
    check(1'b0, "job never finished", 0, 1);
  endtask

  task automatic runGood(input logic [15:0] base, input int n, input logic g,
                         input int bd, input int ed);
    int bursts, bad;
    gaps = g; errMode = 1'b0; errBits = '0; stuck = 1'b0; bufDelay = bd; exitDelay = ed;
    launch(base, n);
    check(busy && !done, "R11 busy set, done cleared after start", {busy, done}, 2);
    waitDone();
    bursts = (n + 31) / 32;
    check(!busy && done, "R11 done without busy at end", {busy, done}, 1);
    check(errCode == 3'd0, "R9 result ok", errCode, 0);
    check(wIdx == 3 + 32 * bursts, "R6 write count", wIdx, 3 + 32 * bursts);
    check(wAddr[0] == base && wData[0] == 16'h0080, "R2 setup write", wData[0], 16'h0080);
    check(wAddr[1] == base && wData[1] == 16'h00D0, "R2 confirm write", wData[1], 16'h00D0);
    check(firstReadCyc - confirmCyc >= DLY, "R3 startup gap", firstReadCyc - confirmCyc, DLY);
    bad = 0;
    for (int k = 0; k < 32 * bursts; k++) begin
      if (wAddr[2 + k] != base) bad++;
      if (wData[2 + k] != ((k < n) ? 16'h5A00 + 16'(k) : 16'hFFFF)) bad++;
    end
    check(bad == 0, "R6 R7 burst address, order and padding", bad, 0);
    check(sent == n, "R8 stream words consumed", sent, n);
    check(wAddr[wIdx - 1] == base + 16'd1024 && wData[wIdx - 1] == 16'hFFFF,
          "R9 exit write", wAddr[wIdx - 1], base + 16'd1024);
    check(viol == 0, "R5 burst started without buffer grant", viol, 0);
    check(!rwClash, "R12 read/write clash", rwClash, 0);
  endtask

  task automatic runSetupErr(input logic [7:0] bits, input logic [2:0] exp);
    gaps = 1'b0; errMode = 1'b1; errBits = bits; stuck = 1'b0; bufDelay = 0; exitDelay = 0;
    launch(16'h0800, 10);
    waitDone();
    check(errCode == exp, "R4 setup error cause", errCode, exp);
    check(wIdx == 2 && sent == 0, "R4 no writes after error", wIdx, 2);
  endtask

  task automatic runAlign(input logic [15:0] base);
    gaps = 1'b0; errMode = 1'b0; errBits = '0; stuck = 1'b0; bufDelay = 0; exitDelay = 0;
    launch(base, 4);
    check(done && errCode == 3'd1 && !busy, "R1 alignment reject", errCode, 1);
    repeat (5) @(negedge clk);
    check(wIdx == 0 && rCount == 0 && !busy, "R1 no bus activity", wIdx + rCount, 0);
  endtask

  initial begin
    inData = '0; inValid = 1'b0;
    modelClr = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !flWe && !flRe && !inReady && errCode == 3'd0,
          "R11 reset state", {busy, done, flWe, flRe, inReady}, 0);
    rstN = 1'b1;
    modelClr = 1'b0;

    runGood(16'h0400, 0,  1'b0, 1, 2);
    runGood(16'h0420, 1,  1'b1, 0, 0);
    runGood(16'h1000, 5,  1'b0, 3, 1);
    runGood(16'h2000, 31, 1'b1, 2, 3);
    runGood(16'h3FE0, 32, 1'b0, 0, 0);
    runGood(16'h0040, 33, 1'b1, 5, 2);
    runGood(16'h8000, 64, 1'b0, 1, 1);
    runGood(16'hFFE0, 70, 1'b1, 2, 4);

    runSetupErr(8'h02, 3'd2);
    runSetupErr(8'h08, 3'd3);
    runSetupErr(8'h0A, 3'd2);
    runSetupErr(8'h00, 3'd4);

    runAlign(16'h0001);
    runAlign(16'h0010);
    runAlign(16'h1F1F);

    // buffer never becomes available
    gaps = 1'b0; errMode = 1'b0; stuck = 1'b1; bufDelay = 0; exitDelay = 0;
    launch(16'h0C00, 8);
    waitDone();
    check(errCode == 3'd5, "R10 setup poll timeout code", errCode, 5);
    check(rCount == LIMIT, "R10 read count at timeout", rCount, LIMIT);
    check(wIdx == 2, "R10 no data after timeout", wIdx, 2);

    // device never reports ready after exit
    stuck = 1'b0; exitDelay = 100;
    launch(16'h0C00, 3);
    waitDone();
    check(errCode == 3'd5, "R10 exit poll timeout code", errCode, 5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule